// File: doc/BRIEF.md
# Oversampled SPI Byte Receiver

This block is an SPI target that receives one byte per frame from an external controller over four wires: active-low chip select, serial clock, controller-to-target data (MOSI) and target-to-controller data (MISO). None of the bus wires is used as a clock. Each one is sampled by the system clock through a two-stage synchronizer, and the block finds all bus edges by comparing the synchronized value with a copy delayed by one more register. The system clock must run at least four times faster than the serial clock.

The block raises a one-cycle pulse when chip select goes low (frame start) and another when it goes high (frame end). Between these it shifts in MOSI bits, most significant bit first, on rising serial-clock edges, as in SPI mode 0. At frame end the received byte is copied to an 8-bit parallel output, for example one that drives LEDs, but only when the frame carried exactly eight bits. A reply byte supplied on a parallel input is taken at frame start and shifted out on MISO, most significant bit first.

The chip-select synchronizer and its delay stage reset to the idle-high level. A reset therefore never produces a false start pulse while the line is idle.

Top module: `spi_byte_rx`

## Requirements
- R1: Each bus input passes through two system-clock flip-flops. A chip-select fall, driven just after rising edge P0, makes frame_start_o high in the cycle after rising edge P2 and for that one cycle only.
- R2: A chip-select rise makes frame_end_o high for exactly one system-clock cycle, with the same latency as R1, once per frame.
- R3: While chip select stays high, frame_start_o never goes high. This holds after the first reset release and after any later reset, because the chip-select synchronizer and delay stages reset to 1.
- R4: While the synchronized chip select is low, each synchronized rising serial-clock edge shifts the synchronized MOSI bit into the receive register. The first bit received becomes bit 7 of the byte.
- R5: The bit count clears at frame start and saturates one above eight. At frame end rx_byte_o takes the received byte only if the count is exactly 8. Otherwise rx_byte_o keeps its previous value. Reset sets rx_byte_o to 0x00.
- R6: rx_byte_o changes only in the cycle that follows a frame_end_o pulse.
- R7: tx_byte_i is captured at frame start. miso_o presents bit 7 first, then bit 6 and so on, and advances by one bit on each synchronized falling serial-clock edge while chip select is low.
- R8: miso_o is 0 whenever the synchronized chip select is high.
- R9: A serial-clock rising edge detected in the same cycle as frame start is not counted, because frame start takes priority. A rising edge detected in the frame-end cycle is also not counted, and the bit count stays unchanged across the frame-end cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Bus chip select, active low, asynchronous |
| sck_i | input | 1 | Bus serial clock, asynchronous |
| mosi_i | input | 1 | Bus data from the controller, asynchronous |
| tx_byte_i | input | 8 | Reply byte, captured at frame start |
| miso_o | output | 1 | Bus data to the controller |
| frame_start_o | output | 1 | One-cycle pulse on chip-select fall |
| frame_end_o | output | 1 | One-cycle pulse on chip-select rise |
| rx_byte_o | output | 8 | Last byte from a complete eight-bit frame |

## Verification
A frame boundary and a serial-clock edge can be detected in the same system-clock cycle. The bench provokes both cases on purpose. In one it drives the serial clock high in the same step that chip select falls, and in the other in the same step that chip select rises, so the two inputs cross identical synchronizers side by side. Each such frame then carries eight normal bits. The byte must appear on rx_byte_o, which shows the clashing edge was not counted: counting it would make the frame nine bits long, and the output would keep its old value.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  // width needed to count 0 .. bits+1
  function automatic int unsigned cnt_width(input int unsigned bits);
    return $clog2(bits + 2);
  endfunction

  // saturating increment of the bit count
  function automatic int unsigned sat_inc(input int unsigned c, input int unsigned lim);
    return (c >= lim) ? lim : c + 1;
  endfunction

  // a frame is accepted only with the exact bit count
  function automatic logic frame_ok(input int unsigned c, input int unsigned bits);
    return c == bits;
  endfunction
endpackage

// File: rtl/spi_sync_bit.sv
module spi_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_i,
  output logic rise_o,
  output logic fall_o
);
  logic dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly <= RST_VAL;
    else        dly <= s_i;
  end

  assign rise_o = ~dly & s_i;
  assign fall_o = dly & ~s_i;
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int BITS = 8,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_low_i,
  input  logic            start_i,
  input  logic            finish_i,
  input  logic            sck_rise_i,
  input  logic            sck_fall_i,
  input  logic            mosi_i,
  input  logic [BITS-1:0] tx_byte_i,
  output logic [BITS-1:0] rx_byte_o,
  output logic            miso_o,
  output logic [CW-1:0]   bit_cnt_o
);
  import spi_rx_pkg::*;

  logic [CW-1:0]   cnt;
  logic [BITS-1:0] rx_sh;
  logic [BITS-1:0] tx_sh;
  logic [BITS-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rx_sh <= '0;
      tx_sh <= '0;
      rx_q  <= '0;
    end else begin
      if (start_i) begin
        cnt   <= '0;
        tx_sh <= tx_byte_i;
      end else if (cs_low_i) begin
        if (sck_rise_i) begin
          rx_sh <= {rx_sh[BITS-2:0], mosi_i};
          cnt   <= CW'(sat_inc(int'(cnt), BITS + 1));
        end
        if (sck_fall_i) tx_sh <= {tx_sh[BITS-2:0], 1'b0};
      end
      if (finish_i && frame_ok(int'(cnt), BITS)) rx_q <= rx_sh;
    end
  end

  assign miso_o    = cs_low_i & tx_sh[BITS-1];
  assign rx_byte_o = rx_q;
  assign bit_cnt_o = cnt;
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx #(
  parameter int BITS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_i,
  input  logic            sck_i,
  input  logic            mosi_i,
  input  logic [BITS-1:0] tx_byte_i,
  output logic            miso_o,
  output logic            frame_start_o,
  output logic            frame_end_o,
  output logic [BITS-1:0] rx_byte_o
);
  localparam int CW = spi_rx_pkg::cnt_width(BITS);
  localparam int NLINES = 3;
  // line order: 0 = chip select (idle high), 1 = serial clock, 2 = data
  localparam logic [NLINES-1:0] LINE_RST = 3'b001;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] sync_lines;
  logic              cs_sync, sck_sync, mosi_sync;
  logic              cs_rise, cs_fall, sck_rise, sck_fall;
  logic [CW-1:0]     bit_cnt;

  assign raw_lines = {mosi_i, sck_i, cs_n_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    spi_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_RST[g])) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_lines[g]), .q_o(sync_lines[g]));
  end

  assign cs_sync   = sync_lines[0];
  assign sck_sync  = sync_lines[1];
  assign mosi_sync = sync_lines[2];

  spi_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .s_i(cs_sync), .rise_o(cs_rise), .fall_o(cs_fall));

  spi_edge_det #(.RST_VAL(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .s_i(sck_sync), .rise_o(sck_rise), .fall_o(sck_fall));

  spi_rx_shift #(.BITS(BITS), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_low_i(~cs_sync), .start_i(cs_fall),
    .finish_i(cs_rise), .sck_rise_i(sck_rise), .sck_fall_i(sck_fall),
    .mosi_i(mosi_sync), .tx_byte_i(tx_byte_i), .rx_byte_o(rx_byte_o),
    .miso_o(miso_o), .bit_cnt_o(bit_cnt));

  assign frame_start_o = cs_fall;
  assign frame_end_o   = cs_rise;
endmodule

// File: rtl/spi_byte_rx_chk.sv
module spi_byte_rx_chk #(
  parameter int BITS = 8,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n_i,
  input logic            frame_start_o,
  input logic            frame_end_o,
  input logic            miso_o,
  input logic [BITS-1:0] rx_byte_o,
  input logic [CW-1:0]   bit_cnt
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o); // R1

  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> !frame_end_o); // R2

  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> !$past(cs_n_i, 2)); // R3

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> (bit_cnt == '0)); // R5

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CW'(BITS + 1)); // R5

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_o |=> $stable(rx_byte_o)); // R6

  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i, 2) |-> !miso_o); // R8

  AST_END_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> $stable(bit_cnt)); // R9
endmodule

bind spi_byte_rx spi_byte_rx_chk #(.BITS(BITS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .frame_start_o(frame_start_o),
  .frame_end_o(frame_end_o), .miso_o(miso_o), .rx_byte_o(rx_byte_o),
  .bit_cnt(bit_cnt));

// File: tb/tb_spi_byte_rx.sv
module tb_spi_byte_rx;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       miso, frame_start, frame_end;
  logic [7:0] rx_byte;

  int   n_checks = 0, n_fail = 0;
  int   fs_cnt = 0, fe_cnt = 0;
  logic fs_prev = 1'b0, fe_prev = 1'b0;
  logic [7:0] exp_rx = 8'h00;
  bit   done = 0;

  always #5 clk = ~clk;

  spi_byte_rx dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .tx_byte_i(tx_byte), .miso_o(miso), .frame_start_o(frame_start),
    .frame_end_o(frame_end), .rx_byte_o(rx_byte));

  function automatic logic [7:0] model_rx(input logic [7:0] old, input int nbits,
                                          input logic [7:0] data);
    return (nbits == 8) ? data : old;
  endfunction

  function automatic logic model_miso(input logic [7:0] txb, input int idx);
    return txb[7 - idx];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // pulse counters and one-cycle width checks (R1, R2)
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_start) fs_cnt++;
      if (frame_end)   fe_cnt++;
      if (frame_start && fs_prev) check("R1 start width", 2, 1);
      if (frame_end && fe_prev)   check("R2 end width", 2, 1);
      fs_prev <= frame_start;
      fe_prev <= frame_end;
    end
  end

  task automatic run_frame(input int nbits, input logic [7:0] data, input logic [7:0] txb,
                           input bit lead, input bit trail);
    int fs0;
    int fe0;
    fs0 = fs_cnt;
    fe0 = fe_cnt;
    tx_byte = txb;
    tick();
    cs_n = 1'b0;
    if (lead) sck = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 start not before second edge", frame_start, 0);
    @(negedge clk);
    check("R1 start after second edge", frame_start, 1);
    if (lead) begin
      repeat (HALF) tick();
      sck = 1'b0;
    end
    repeat (HALF) tick();
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? data[7 - i] : 1'b1;
      repeat (HALF) tick();
      if (!lead && i < 8) check("R7 miso bit", miso, model_miso(txb, i));
      sck = 1'b1;
      repeat (HALF) tick();
      sck = 1'b0;
    end
    repeat (HALF) tick();
    cs_n = 1'b1;
    if (trail) sck = 1'b1;
    repeat (HALF) tick();
    sck = 1'b0;
    repeat (HALF) tick();
    exp_rx = model_rx(exp_rx, nbits, data);
    check("R1 one start per frame", fs_cnt - fs0, 1);
    check("R2 one end per frame", fe_cnt - fe0, 1);
    check("R8 miso idle", miso, 0);
    check(nbits == 8 ? "R4 R5 byte taken" : "R5 byte kept", rx_byte, exp_rx);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    check("R5 reset rx", rx_byte, 8'h00);
    check("R8 reset miso", miso, 0);
    rst_n = 1'b1;
    repeat (30) tick();
    check("R3 no start after reset", fs_cnt, 0);
    // directed frames
    run_frame(8, 8'hA5, 8'h3C, 0, 0);
    run_frame(7, 8'h5A, 8'hC3, 0, 0);
    run_frame(9, 8'h77, 8'hFF, 0, 0);
    run_frame(0, 8'h11, 8'h80, 0, 0);
    run_frame(8, 8'hFF, 8'h01, 0, 0);
    run_frame(8, 8'h00, 8'hFE, 0, 0);
    // R9: sck edges in the same cycle as start / end
    run_frame(8, 8'hC9, 8'h00, 1, 0);
    run_frame(8, 8'h36, 8'hAA, 0, 1);
    run_frame(8, 8'h4B, 8'h55, 1, 1);
    // R3: reset again with chip select idle
    begin
      int fs_before;
      fs_before = fs_cnt;
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      exp_rx = 8'h00;
      repeat (20) tick();
      check("R3 no start after later reset", fs_cnt - fs_before, 0);
      check("R5 rx cleared by reset", rx_byte, 8'h00);
    end
    // constrained random frames
    for (int k = 0; k < 40; k++) begin
      int nb;
      nb = ($urandom_range(0, 3) != 0) ? 8 : int'($urandom_range(0, 11));
      run_frame(nb, 8'($urandom), 8'($urandom), 0, 0);
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule